// File: doc/BRIEF.md
# Least-Recently-Executed Thread Selector

This block is the thread-select stage of a fine-grained multithreaded in-order core with four hardware threads. It sits second in a six-stage pipeline: fetch, thread select, decode, execute, memory, writeback. On every clock edge it registers a grant for one eligible thread, whose instruction goes on to decode. It can move to a different thread on every cycle at no cost.

The selector keeps an age order of the threads. Among the eligible threads, the grant goes to the one that issued least recently, and the granted thread becomes the newest. A thread is eligible when three things hold: its external ready mask bit is high, its internal status is ready, and no stall event (cache miss, trap, resource conflict) hits it in the current cycle.

Issuing a long-latency instruction parks the thread. A load is assumed to hit in the cache and the thread frees itself after a fixed latency. A miss holds the thread until a fill pulse arrives. A branch, a multiply, a divide, a trap or a conflict holds the thread until a completion pulse arrives.

Top module: `strand_picker`

## Requirements
- R1: After reset, issue_vld_o, grant_o and grant_idx_o are zero, all threads are ready, and the age order runs from thread 0 (oldest) to thread 3 (newest). With every thread available, the first grant goes to thread 0.
- R2: The grant appears one cycle after the inputs it was computed from. grant_o is zero or one-hot. issue_vld_o is high exactly when grant_o is non-zero. grant_o has bit grant_idx_o set.
- R3: The grant goes to the least recently granted eligible thread, and that thread becomes the newest in the same edge. The rule is not round-robin: after thread 2 issues alone twice, the next four grants with every thread available are 0, 1, 3, 2.
- R4: When no thread is eligible, issue_vld_o is low, grant_o is zero and the age order does not change.
- R5: cls_i bits [2t+1:2t] give thread t's instruction class: 0 simple, 1 load, 2 or 3 long (branch, multiply, divide). After a load issues, the thread is not eligible for LOAD_LAT-1 cycles and can issue again LOAD_LAT cycles after the load, unless a miss arrives first.
- R6: A miss_i pulse holds the thread not ready until a fill_i pulse for that thread. done_i does not release it.
- R7: After a long-class instruction issues, the thread stays not ready until a done_i pulse for it. fill_i does not release it.
- R8: A trap_i or conflict_i pulse removes the thread from that cycle's pick and holds it until done_i. The pick falls to the next-oldest eligible thread.
- R9: When a block event (miss, trap, conflict) and a wake event (fill, done) hit one thread in the same cycle, the thread stays blocked.
- R10: A thread whose avail_i bit is low is not granted, and this leaves its status and age unchanged.
- R11: A thread issuing simple-class instructions stays eligible and can be granted on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| avail_i | input | NUM_THR | External per-thread ready mask |
| cls_i | input | 2*NUM_THR | Per-thread class of the fetched instruction, 2 bits each |
| miss_i | input | NUM_THR | Per-thread cache-miss pulse |
| trap_i | input | NUM_THR | Per-thread trap pulse |
| conflict_i | input | NUM_THR | Per-thread resource-conflict pulse |
| fill_i | input | NUM_THR | Per-thread fill-complete pulse |
| done_i | input | NUM_THR | Per-thread completion or clear pulse |
| grant_o | output | NUM_THR | Registered one-hot grant |
| grant_idx_o | output | $clog2(NUM_THR) | Index of the granted thread |
| issue_vld_o | output | 1 | A thread was granted this cycle |

## Verification
The bench builds the block with its default parameters, four threads and a load latency of three cycles. With four threads, every position of the age order can be reached, including moving a thread from the middle of the order to the newest slot. This is what separates age order from round-robin. A three-cycle latency gives a load shadow of two cycles, short enough to check edge by edge, and it lets a miss or a stray completion pulse land while a thread is parked.

// File: rtl/strand_pick_pkg.sv
package strand_pick_pkg;
    typedef enum logic [1:0] {
        CLS_SIMPLE = 2'd0,
        CLS_LOAD   = 2'd1,
        CLS_LONG   = 2'd2,
        CLS_LONG2  = 2'd3
    } instr_cls_e;

    typedef enum logic [1:0] {
        ST_RDY  = 2'd0,
        ST_LOAD = 2'd1,
        ST_MISS = 2'd2,
        ST_LONG = 2'd3
    } thr_st_e;
endpackage

// File: rtl/strand_status.sv
module strand_status
    import strand_pick_pkg::*;
#(
    parameter int LOAD_LAT = 3,
    localparam int CNT_W = $clog2(LOAD_LAT + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       issue_i,
    input  logic [1:0] cls_i,
    input  logic       miss_i,
    input  logic       stall_i,
    input  logic       fill_i,
    input  logic       done_i,
    output logic       rdy_o
);
    typedef struct packed {
        thr_st_e          st;
        logic [CNT_W-1:0] cnt;
    } stat_t;

    stat_t q, d;

    always_comb begin
        d = q;
        // wake-up paths
        case (q.st)
            ST_LOAD: begin
                if (q.cnt <= CNT_W'(1)) d.st = ST_RDY;
                else                    d.cnt = q.cnt - CNT_W'(1);
            end
            ST_MISS: if (fill_i) d.st = ST_RDY;
            ST_LONG: if (done_i) d.st = ST_RDY;
            default: ;
        endcase
        // issue of a long-latency instruction parks the thread
        if (issue_i) begin
            case (instr_cls_e'(cls_i))
                CLS_SIMPLE: ;
                CLS_LOAD: begin
                    d.st  = ST_LOAD;
                    d.cnt = CNT_W'(LOAD_LAT - 1);
                end
                default: d.st = ST_LONG;
            endcase
        end
        // block events come last so they win over wake-ups
        if (stall_i) d.st = ST_LONG;
        if (miss_i)  d.st = ST_MISS;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st  <= ST_RDY;
            q.cnt <= '0;
        end else begin
            q <= d;
        end
    end

    assign rdy_o = (q.st == ST_RDY);

    // R5
    load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && cls_i == 2'd1 && !miss_i && !stall_i) |=> (q.st == ST_LOAD));

    // R6
    miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_MISS && !fill_i) |=> !rdy_o);

    // R7
    long_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_LONG && !done_i) |=> !rdy_o);

    // R9
    block_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((miss_i || stall_i) && (fill_i || done_i)) |=> !rdy_o);
endmodule

// File: rtl/strand_lru.sv
module strand_lru #(
    parameter int NUM_THR = 4,
    localparam int IW = $clog2(NUM_THR)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_THR-1:0] elig_i,
    output logic               pick_vld_o,
    output logic [IW-1:0]      pick_idx_o,
    output logic [NUM_THR-1:0] pick_oh_o
);
    typedef struct packed {
        logic [NUM_THR-1:0][IW-1:0] ord;  // ord[0] oldest
    } age_t;

    age_t q, d;
    int   pos;

    always_comb begin
        d          = q;
        pick_vld_o = 1'b0;
        pick_idx_o = '0;
        pos        = 0;
        for (int i = 0; i < NUM_THR; i++) begin
            if (!pick_vld_o && elig_i[q.ord[i]]) begin
                pick_vld_o = 1'b1;
                pick_idx_o = q.ord[i];
                pos        = i;
            end
        end
        if (pick_vld_o) begin
            for (int i = 0; i < NUM_THR - 1; i++) begin
                if (i >= pos) d.ord[i] = q.ord[i+1];
            end
            d.ord[NUM_THR-1] = pick_idx_o;
        end
        pick_oh_o = pick_vld_o ? (NUM_THR'(1) << pick_idx_o) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_THR; i++) q.ord[i] <= IW'(i);
        end else begin
            q <= d;
        end
    end

    // R4
    order_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pick_vld_o |=> (q.ord == $past(q.ord)));

    // R3
    newest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pick_vld_o |=> (q.ord[NUM_THR-1] == $past(pick_idx_o)));
endmodule

// File: rtl/strand_picker.sv
module strand_picker #(
    parameter int NUM_THR  = 4,
    parameter int LOAD_LAT = 3,
    localparam int IW = $clog2(NUM_THR)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_THR-1:0]   avail_i,
    input  logic [2*NUM_THR-1:0] cls_i,
    input  logic [NUM_THR-1:0]   miss_i,
    input  logic [NUM_THR-1:0]   trap_i,
    input  logic [NUM_THR-1:0]   conflict_i,
    input  logic [NUM_THR-1:0]   fill_i,
    input  logic [NUM_THR-1:0]   done_i,
    output logic [NUM_THR-1:0]   grant_o,
    output logic [IW-1:0]        grant_idx_o,
    output logic                 issue_vld_o
);
    typedef struct packed {
        logic [NUM_THR-1:0] grant;
        logic [IW-1:0]      idx;
        logic               vld;
    } out_t;

    out_t q, d;

    logic [NUM_THR-1:0] rdy;
    logic [NUM_THR-1:0] blk;
    logic [NUM_THR-1:0] elig;
    logic               pick_vld;
    logic [IW-1:0]      pick_idx;
    logic [NUM_THR-1:0] pick_oh;

    assign blk  = miss_i | trap_i | conflict_i;
    assign elig = avail_i & rdy & ~blk;

    for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
        strand_status #(.LOAD_LAT(LOAD_LAT)) u_stat (
            .clk     (clk),
            .rst_n   (rst_n),
            .issue_i (pick_oh[t]),
            .cls_i   (cls_i[2*t+1 -: 2]),
            .miss_i  (miss_i[t]),
            .stall_i (trap_i[t] | conflict_i[t]),
            .fill_i  (fill_i[t]),
            .done_i  (done_i[t]),
            .rdy_o   (rdy[t])
        );
    end

    strand_lru #(.NUM_THR(NUM_THR)) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .elig_i     (elig),
        .pick_vld_o (pick_vld),
        .pick_idx_o (pick_idx),
        .pick_oh_o  (pick_oh)
    );

    always_comb begin
        d.grant = pick_oh;
        d.idx   = pick_idx;
        d.vld   = pick_vld;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign grant_o     = q.grant;
    assign grant_idx_o = q.idx;
    assign issue_vld_o = q.vld;

    // R2
    onehot_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o) && (issue_vld_o == (grant_o != '0)));

    // R2
    idx_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_vld_o |-> grant_o[grant_idx_o]);

    // R8
    stalled_not_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pick_vld |=> ((grant_o & $past(blk)) == '0));

    // R10
    unavail_not_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pick_vld |=> ((grant_o & ~$past(avail_i)) == '0));
endmodule

// File: tb/strand_picker_test.sv
module strand_picker_test;
    localparam int N  = 4;
    localparam int IW = 2;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [N-1:0]   avail_i;
    logic [2*N-1:0] cls_i;
    logic [N-1:0]   miss_i, trap_i, conflict_i, fill_i, done_i;
    logic [N-1:0]   grant_o;
    logic [IW-1:0]  grant_idx_o;
    logic           issue_vld_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    strand_picker #(.NUM_THR(N), .LOAD_LAT(3)) uut (
        .clk(clk), .rst_n(rst_n), .avail_i(avail_i), .cls_i(cls_i),
        .miss_i(miss_i), .trap_i(trap_i), .conflict_i(conflict_i),
        .fill_i(fill_i), .done_i(done_i), .grant_o(grant_o),
        .grant_idx_o(grant_idx_o), .issue_vld_o(issue_vld_o)
    );

    task automatic clear_pulses();
        miss_i = '0; trap_i = '0; conflict_i = '0; fill_i = '0; done_i = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        clear_pulses();
    endtask

    task automatic do_reset();
        rst_n   = 1'b0;
        avail_i = '1;
        cls_i   = '0;
        clear_pulses();
        @(posedge clk);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    task automatic set_cls(input int t, input logic [1:0] c);
        cls_i[2*t +: 2] = c;
    endtask

    task automatic expect_grant(input string req, input bit ev, input int eidx);
        logic [N-1:0] eg;
        eg = ev ? (N'(1) << eidx) : '0;
        checks++;
        if (issue_vld_o !== ev || grant_o !== eg || (ev && grant_idx_o !== IW'(eidx))) begin
            errors++;
            $display("FAIL %s: vld=%0d grant=%b idx=%0d expected vld=%0d grant=%b idx=%0d",
                     req, issue_vld_o, grant_o, grant_idx_o, ev, eg, eidx);
        end
    endtask

    // R1: reset state and first grant
    task automatic t_reset();
        do_reset();
        expect_grant("R1 reset", 0, 0);
        tick();
        expect_grant("R1 first grant", 1, 0);
    endtask

    // R2 R3: all available cycles through in age order
    task automatic t_rotate();
        do_reset();
        for (int k = 0; k < 5; k++) begin
            tick();
            expect_grant("R2 R3 all avail", 1, k % 4);
        end
    endtask

    // R3: age order differs from round-robin
    task automatic t_age();
        int exp_seq[4] = '{0, 1, 3, 2};
        do_reset();
        avail_i = 4'b0100;
        tick(); expect_grant("R3 solo", 1, 2);
        tick(); expect_grant("R3 solo", 1, 2);
        avail_i = '1;
        for (int k = 0; k < 4; k++) begin
            tick();
            expect_grant("R3 age order", 1, exp_seq[k]);
        end
    endtask

    // R4: nothing eligible holds the order
    task automatic t_idle();
        do_reset();
        tick(); expect_grant("R4 pre", 1, 0);
        avail_i = '0;
        tick(); expect_grant("R4 idle", 0, 0);
        tick(); expect_grant("R4 idle", 0, 0);
        avail_i = '1;
        tick(); expect_grant("R4 order kept", 1, 1);
    endtask

    // R5: load shadow
    task automatic t_load();
        do_reset();
        avail_i = 4'b0001;
        set_cls(0, 2'd1);
        tick(); expect_grant("R5 load issue", 1, 0);
        set_cls(0, 2'd0);
        tick(); expect_grant("R5 shadow", 0, 0);
        tick(); expect_grant("R5 shadow", 0, 0);
        tick(); expect_grant("R5 reissue", 1, 0);
    endtask

    // R6: miss held until fill
    task automatic t_miss();
        do_reset();
        avail_i = 4'b0010;
        set_cls(1, 2'd1);
        tick(); expect_grant("R6 load issue", 1, 1);
        set_cls(1, 2'd0);
        miss_i[1] = 1'b1;
        tick(); expect_grant("R6 miss", 0, 0);
        tick(); expect_grant("R6 held", 0, 0);
        done_i[1] = 1'b1;
        tick(); expect_grant("R6 done ignored", 0, 0);
        tick(); expect_grant("R6 done ignored", 0, 0);
        fill_i[1] = 1'b1;
        tick(); expect_grant("R6 fill edge", 0, 0);
        tick(); expect_grant("R6 released", 1, 1);
    endtask

    // R7: long class held until done
    task automatic t_long();
        do_reset();
        avail_i = 4'b1000;
        set_cls(3, 2'd2);
        tick(); expect_grant("R7 long issue", 1, 3);
        set_cls(3, 2'd0);
        tick(); expect_grant("R7 held", 0, 0);
        fill_i[3] = 1'b1;
        tick(); expect_grant("R7 fill ignored", 0, 0);
        tick(); expect_grant("R7 fill ignored", 0, 0);
        done_i[3] = 1'b1;
        tick(); expect_grant("R7 done edge", 0, 0);
        tick(); expect_grant("R7 released", 1, 3);
    endtask

    // R8: trap masks and holds
    task automatic t_trap();
        do_reset();
        trap_i[0] = 1'b1;
        tick(); expect_grant("R8 trap masks", 1, 1);
        tick(); expect_grant("R8 next", 1, 2);
        tick(); expect_grant("R8 next", 1, 3);
        done_i[0] = 1'b1;
        tick(); expect_grant("R8 still held", 1, 1);
        tick(); expect_grant("R8 released oldest", 1, 0);
    endtask

    // R9: block beats wake in same cycle
    task automatic t_prio();
        do_reset();
        avail_i = 4'b0100;
        set_cls(2, 2'd3);
        tick(); expect_grant("R9 long issue", 1, 2);
        set_cls(2, 2'd0);
        conflict_i[2] = 1'b1;
        done_i[2]     = 1'b1;
        tick(); expect_grant("R9 same cycle", 0, 0);
        tick(); expect_grant("R9 stays blocked", 0, 0);
        done_i[2] = 1'b1;
        tick(); expect_grant("R9 done edge", 0, 0);
        tick(); expect_grant("R9 released", 1, 2);
    endtask

    // R10: unavailable thread keeps its age and status
    task automatic t_avail();
        do_reset();
        avail_i = 4'b1110;
        tick(); expect_grant("R10 masked", 1, 1);
        tick(); expect_grant("R10 masked", 1, 2);
        avail_i = '1;
        tick(); expect_grant("R10 kept oldest", 1, 0);
        tick(); expect_grant("R10 then", 1, 3);
    endtask

    // R11: simple back-to-back
    task automatic t_simple();
        do_reset();
        avail_i = 4'b0010;
        for (int k = 0; k < 3; k++) begin
            tick();
            expect_grant("R11 back-to-back", 1, 1);
        end
    endtask

    initial begin
        #1500000;
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_rotate();
        t_age();
        t_idle();
        t_load();
        t_miss();
        t_long();
        t_trap();
        t_prio();
        t_avail();
        t_simple();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule